// File: doc/BRIEF.md
# Serial Converter Read Master

This block sits on the host side of a three-wire serial link to an 8-bit successive-approximation converter. A client hands it a channel bit and a single-ended/differential flag over a ready/valid request port. The block then runs one complete read frame on its own. It lowers the chip select, derives a slow serial clock from the system clock, and shifts out a start bit followed by the two address bits. It then collects the conversion result that the converter returns.

The converter sends its result twice: first most significant bit first, then again in the reverse order without repeating the shared bit 0. The block keeps both copies. It returns the first copy as the result and raises a mismatch flag when the second copy disagrees with it. The one settling bit that separates the address from the data is dropped. When the frame is done, chip select goes high and stays high for a programmable number of system clocks before the next request can be taken.

Top module: `adc_serial_reader`

## Requirements
- R1: While `rst` is high, `conv_cs_n` is 1, `conv_sclk` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: While `conv_cs_n` is low, every low half and every high half of `conv_sclk` lasts exactly `HALF_DIV` system clocks. Each frame has exactly 19 rising edges. `conv_sclk` is 0 whenever `conv_cs_n` is high.
- R3: `conv_cs_n` falls on the cycle after a request is accepted, with `conv_sclk` low. It rises at the falling clock edge that ends the 19th period. It then stays high for at least `CS_GAP` system clocks.
- R4: On the first three rising edges, `conv_din` carries 1 (start), then the mode bit (1 = single-ended, which is `req_diff` = 0), then `req_chan`. `conv_din` changes only while `conv_sclk` is low.
- R5: The `conv_dout` bit sampled before the 4th rising edge is discarded and has no effect on `rsp_data` or `rsp_mismatch`.
- R6: The `conv_dout` bits sampled before rising edges 5 to 12 form `rsp_data`, most significant bit first.
- R7: The bits sampled before rising edges 13 to 19 are bits 1 to 7 of the result, in that order. `rsp_mismatch` is 1 exactly when any of them differs from the matching bit of `rsp_data`.
- R8: `rsp_valid` is a single-cycle pulse, exactly one per frame, in the cycle in which `conv_cs_n` rises.
- R9: `req_ready` is 0 from the acceptance of a request until the end of the chip-select-high gap. A request presented while `req_ready` is 0 is not taken and does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | 1 | Channel / polarity select bit |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8 | Conversion result |
| rsp_mismatch | output | 1 | The two serial copies disagree |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_sclk | output | 1 | Serial clock to the converter |
| conv_din | output | 1 | Start and address bits to the converter |
| conv_dout | input | 1 | Serial data from the converter |

## Verification
Three events coincide on one system-clock edge: the falling serial-clock edge that ends the 19th period, the rise of chip select, and the response strobe. The last LSB-first sample is taken only `HALF_DIV` cycles earlier. A model converter answers every frame with a known value. Across a sweep of all 256 values, the bench checks that the response strobe is one cycle wide, that chip select rises in that same cycle, and that the final high half still has its full length. Extra frames corrupt each reversed bit in turn, to show that the mismatch flag uses the last sample even though the frame closes on the next falling edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W         = 8;
  localparam int HDR_BITS      = 3;
  localparam int FIRST_MSB_PER = HDR_BITS + 1;
  localparam int FIRST_LSB_PER = FIRST_MSB_PER + RES_W;
  localparam int LAST_PER      = FIRST_LSB_PER + RES_W - 2;
  localparam int PER_W         = $clog2(LAST_PER + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int HALF_DIV = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_pre,
  output logic fall_pre
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             term;

  assign term     = (cnt == TERM);
  assign rise_pre = run && term && !sclk;
  assign fall_pre = run && term && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_frame_ctrl.sv
module adc_rd_frame_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CS_GAP = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_chan,
  input  logic             req_diff,
  input  logic             fall_pre,
  output logic             req_ready,
  output logic             cs_n,
  output logic             din,
  output logic             run,
  output logic             done,
  output logic [PER_W-1:0] per
);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [PER_W-1:0] PER_END  = PER_W'(LAST_PER);

  rd_state_t        state;
  logic [GAP_W-1:0] gap_cnt;
  logic             chan_q;
  logic             diff_q;
  logic [PER_W-1:0] per_nxt;
  logic             din_nxt;

  assign req_ready = (state == ST_IDLE);
  assign run       = (state == ST_FRAME);
  assign done      = run && fall_pre && (per == PER_END);
  assign per_nxt   = per + 1'b1;

  always_comb begin
    case (per_nxt)
      PER_W'(1): din_nxt = ~diff_q;
      PER_W'(2): din_nxt = chan_q;
      default:   din_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n    <= 1'b1;
      din     <= 1'b0;
      per     <= '0;
      gap_cnt <= '0;
      chan_q  <= 1'b0;
      diff_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_FRAME;
            cs_n   <= 1'b0;
            din    <= 1'b1;
            per    <= '0;
            chan_q <= req_chan;
            diff_q <= req_diff;
          end
        end
        ST_FRAME: begin
          if (fall_pre) begin
            if (per == PER_END) begin
              state   <= ST_GAP;
              cs_n    <= 1'b1;
              din     <= 1'b0;
              gap_cnt <= '0;
            end else begin
              per <= per_nxt;
              din <= din_nxt;
            end
          end
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_rx_capture.sv
module adc_rd_rx_capture
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_pre,
  input  logic             done,
  input  logic [PER_W-1:0] per,
  input  logic             sdo,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_data,
  output logic             rsp_mismatch
);
  localparam logic [PER_W-1:0] MSB_LO = PER_W'(FIRST_MSB_PER);
  localparam logic [PER_W-1:0] LSB_LO = PER_W'(FIRST_LSB_PER);

  logic [RES_W-1:0] msb_sr;
  logic [RES_W-2:0] lsb_sr;
  logic             in_msb;
  logic             in_lsb;
  logic [RES_W-2:0] diff_bits;

  assign in_msb = (per >= MSB_LO) && (per < LSB_LO);
  assign in_lsb = (per >= LSB_LO);

  for (genvar i = 0; i < RES_W - 1; i++) begin : g_cmp
    assign diff_bits[i] = msb_sr[i+1] ^ lsb_sr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_sr       <= '0;
      lsb_sr       <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_mismatch <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (rise_pre && in_msb) msb_sr <= {msb_sr[RES_W-2:0], sdo};
      if (rise_pre && in_lsb) lsb_sr <= {sdo, lsb_sr[RES_W-2:1]};
      if (done) begin
        rsp_data     <= msb_sr;
        rsp_mismatch <= |diff_bits;
      end
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV = 200,
  parameter int CS_GAP   = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_chan,
  input  logic             req_diff,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_data,
  output logic             rsp_mismatch,
  output logic             conv_cs_n,
  output logic             conv_sclk,
  output logic             conv_din,
  input  logic             conv_dout
);
  logic             run;
  logic             rise_pre;
  logic             fall_pre;
  logic             done;
  logic [PER_W-1:0] per;

  adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sclk     (conv_sclk),
    .rise_pre (rise_pre),
    .fall_pre (fall_pre)
  );

  adc_rd_frame_ctrl #(.CS_GAP(CS_GAP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_diff  (req_diff),
    .fall_pre  (fall_pre),
    .req_ready (req_ready),
    .cs_n      (conv_cs_n),
    .din       (conv_din),
    .run       (run),
    .done      (done),
    .per       (per)
  );

  adc_rd_rx_capture u_rx (
    .clk          (clk),
    .rst          (rst),
    .rise_pre     (rise_pre),
    .done         (done),
    .per          (per),
    .sdo          (conv_dout),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_mismatch (rsp_mismatch)
  );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int HALF_DIV = 200
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic conv_cs_n,
  input logic conv_sclk,
  input logic conv_din
);
  localparam int LEN_W = $clog2(HALF_DIV + 2);
  localparam logic [LEN_W-1:0] LEN_MAX  = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(HALF_DIV);

  logic             sclk_q;
  logic [LEN_W-1:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      hi_len <= '0;
    end else begin
      sclk_q <= conv_sclk;
      if (conv_sclk != sclk_q) hi_len <= LEN_W'(1);
      else if (hi_len != LEN_MAX) hi_len <= hi_len + 1'b1;
    end
  end

  AST_CLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    conv_cs_n |-> !conv_sclk); // R2
  AST_HIGH_HALF_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && !conv_sclk) |-> (hi_len == LEN_HALF)); // R2
  AST_SELECT_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_cs_n) |-> (!conv_sclk && conv_din)); // R3
  AST_DIN_MOVES_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (!conv_cs_n && !$stable(conv_din)) |-> !conv_sclk); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_STROBE_AT_DESELECT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(conv_cs_n)); // R8
  AST_READY_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> conv_cs_n); // R9
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .conv_cs_n (conv_cs_n),
  .conv_sclk (conv_sclk),
  .conv_din  (conv_din)
);

// File: tb/adc_serial_reader_test.sv
`timescale 1ns/1ps
module adc_serial_reader_test;
  localparam int HALF = 2;
  localparam int GAP  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_chan  = 1'b0;
  logic       req_diff  = 1'b0;
  logic       conv_dout = 1'b0;
  logic       req_ready, rsp_valid, rsp_mismatch;
  logic       conv_cs_n, conv_sclk, conv_din;
  logic [7:0] rsp_data;

  adc_serial_reader #(.HALF_DIV(HALF), .CS_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_diff(req_diff), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch), .conv_cs_n(conv_cs_n),
    .conv_sclk(conv_sclk), .conv_din(conv_din), .conv_dout(conv_dout)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic [7:0] dev_val = 8'h00;
  logic       dev_settle = 1'b0;
  int         dev_flip = 0;
  int         rcnt = 0;
  logic       cap_start = 1'b0, cap_sgl = 1'b0, cap_odd = 1'b0;

  function automatic logic dev_bit(input int r);
    if (r == 3) return dev_settle;
    if (r >= 4 && r <= 11) return dev_val[11 - r];
    if (r >= 12 && r <= 18) return dev_val[r - 11] ^ (dev_flip == (r - 11));
    return 1'b0;
  endfunction

  always @(posedge conv_sclk or posedge conv_cs_n) begin
    if (conv_cs_n) rcnt <= 0;
    else begin
      case (rcnt)
        0: cap_start <= conv_din;
        1: cap_sgl   <= conv_din;
        2: cap_odd   <= conv_din;
        default: ;
      endcase
      rcnt <= rcnt + 1;
    end
  end

  always @(negedge conv_sclk or posedge conv_cs_n) begin
    if (conv_cs_n) conv_dout <= #1 1'b0;
    else conv_dout <= #1 dev_bit(rcnt);
  end

  // port monitor
  bit prev_cs = 1'b1, prev_sclk = 1'b0, first = 1'b1;
  int len = 0, rises = 0, gap_len = 0, pulse_total = 0;
  bit bad_half = 0, gap_bad = 0, busy_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!conv_cs_n) begin
        if (prev_cs) begin
          len = 1; rises = 0;
          if (!first && gap_len < GAP) gap_bad = 1;
          first = 0;
          if (conv_sclk) bad_half = 1;
        end else if (conv_sclk == prev_sclk) len++;
        else begin
          if (len != HALF) bad_half = 1;
          len = 1;
          if (conv_sclk) rises++;
        end
        if (req_ready) busy_bad = 1;
      end else begin
        if (!prev_cs) begin
          if (len != HALF) bad_half = 1;
          gap_len = 1;
        end else gap_len++;
        if (conv_sclk) bad_half = 1;
      end
      if (rsp_valid) pulse_total++;
      prev_cs = conv_cs_n;
      prev_sclk = conv_sclk;
    end
  end

  task automatic run_frame(input bit ch, input bit df, input logic [7:0] v,
                           input bit st, input int fl, input bit busy);
    int waitc;
    int p0;
    dev_val = v; dev_settle = st; dev_flip = fl;
    waitc = 0;
    while (!req_ready && waitc < 1000) begin @(negedge clk); waitc++; end
    req_chan = ch; req_diff = df; req_valid = 1'b1;
    p0 = pulse_total;
    @(negedge clk);
    if (busy) begin req_chan = ~ch; req_diff = ~df; end
    else req_valid = 1'b0;
    waitc = 0;
    while (!rsp_valid && waitc < 1000) begin @(negedge clk); waitc++; end
    req_valid = 1'b0;
    check(rsp_data == v, "R6 data", rsp_data, v);
    check(rsp_mismatch == (fl != 0), "R7 mismatch", rsp_mismatch, fl != 0);
    check(cap_start == 1'b1, "R4 start bit", cap_start, 1);
    check(cap_sgl == ~df, "R4 mode bit", cap_sgl, ~df);
    check(cap_odd == ch, "R4/R9 channel bit", cap_odd, ch);
    check(rises == 19, "R2 rising edges", rises, 19);
    check(conv_cs_n == 1'b1, "R3 cs high with strobe", conv_cs_n, 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 strobe width", rsp_valid, 0);
    check(pulse_total - p0 == 1, "R8 one strobe per frame", pulse_total - p0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(conv_cs_n == 1'b1, "R1 cs_n", conv_cs_n, 1);
    check(conv_sclk == 1'b0, "R1 sclk", conv_sclk, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R6 R5 R4: full value sweep, settling bit driven to both levels
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      run_frame(vb[0], vb[1], vb, vb[3] ^ vb[5], 0, 1'b0);
    end
    // R5: settling bit high on an all-zero result
    run_frame(1'b0, 1'b0, 8'h00, 1'b1, 0, 1'b0);
    // R7: corrupt each reversed-copy bit in turn
    for (int k = 1; k <= 7; k++) run_frame(k[0], k[1], 8'h5A ^ 8'(k), 1'b0, k, 1'b0);
    // R9: request held with altered fields during a frame
    run_frame(1'b1, 1'b0, 8'h3C, 1'b1, 0, 1'b1);
    run_frame(1'b0, 1'b1, 8'hC3, 1'b0, 0, 1'b0);
    check(bad_half == 0, "R2 half-period length", bad_half, 0);
    check(gap_bad == 0, "R3 cs high gap", gap_bad, 0);
    check(busy_bad == 0, "R9 ready while busy", busy_bad, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule